// File: doc/BRIEF.md
# ADC Regular-Sequence Scan Controller

This block sequences an analog-to-digital converter core through a programmed list of up to sixteen 5-bit channel numbers. Software starts a pass with a start pulse or an external event pulses a trigger. The controller then hands each channel to the converter through a start/done handshake. It stores each returned sample in a single result register and pulses a DMA request so that a transfer engine can collect every sample before the next one overwrites it.

Three modes are built on the same position counter. Scan mode walks the whole list once per trigger. Continuous scan begins again at entry 0 as soon as the final entry finishes. Discontinuous mode splits the list into bursts of a programmed size. Each trigger converts the next burst, picking up where the previous burst stopped. The end-of-sequence flag is set only when the final list entry has converted. It raises an interrupt when its enable bit is set, and it stays set until software clears it.

Top module: `adc_seq_scan`

## Requirements
- R1: Within a sequence, conversions follow list order from entry 0, and the channel presented on `convChan` with `convStart` is `cfgChanList[5*i+4:5*i]` for entry i.
- R2: A sequence starts only when `cfgEnable` is 1 and `swStart` or `extTrig` is pulsed; a trigger while `cfgEnable` is 0 starts nothing.
- R3: Every `convDone` received for a requested conversion loads `convData` into `resultData` and produces exactly one 1-cycle `dmaReq` pulse; `resultData` is otherwise held.
- R4: `eocFlag` is set in the same cycle as the result of the final list entry and not after any earlier entry.
- R5: `eocIrq` is high exactly when `eocFlag` and `cfgEocIe` are both 1.
- R6: With `cfgScan`=1, `cfgCont`=1 and `cfgDisc`=0, the list restarts at entry 0 after its final entry with no further trigger.
- R7: `cfgLenM1` holds the conversion count minus one: with scan mode on, the values 0, 4, 7 and 15 give 1, 5, 8 and 16 conversions per trigger.
- R8: A 1-cycle pulse on `eocClr` clears `eocFlag`; the flag falls at no other time.
- R9: With `cfgDisc`=1, each trigger converts `cfgBurstM1`+1 consecutive entries (1 to 8), starting at the entry after the last one converted.
- R10: In discontinuous mode a burst that reaches the final entry stops there, sets `eocFlag`, and the next trigger begins at entry 0.
- R11: A trigger that arrives while a sequence or burst is running is ignored and does not lengthen it.
- R12: Driving `cfgEnable` to 0 aborts any activity and returns the position to entry 0, so that the next sequence starts at entry 0.
- R13: With `cfgScan`=0, each trigger converts only entry 0 and sets `eocFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Converter enable; 0 aborts and rewinds |
| cfgScan | input | 1 | Scan the whole list (0: entry 0 only) |
| cfgCont | input | 1 | Restart the list automatically after the final entry |
| cfgDisc | input | 1 | Burst (discontinuous) mode |
| cfgBurstM1 | input | 3 | Burst size minus one |
| cfgLenM1 | input | 4 | List length minus one |
| cfgChanList | input | 80 | Channel list, 5 bits per entry, entry 0 in the low bits |
| cfgEocIe | input | 1 | End-of-sequence interrupt enable |
| swStart | input | 1 | Software start pulse |
| extTrig | input | 1 | External trigger pulse |
| eocClr | input | 1 | Pulse that clears the end-of-sequence flag |
| convStart | output | 1 | One-cycle start pulse to the converter |
| convChan | output | 5 | Channel for the requested conversion |
| convDone | input | 1 | Converter completion pulse |
| convData | input | 12 | Converter sample, valid with convDone |
| resultData | output | 12 | Last converted sample |
| dmaReq | output | 1 | One-cycle request per stored sample |
| eocFlag | output | 1 | End-of-sequence flag |
| eocIrq | output | 1 | End-of-sequence interrupt |

## Verification
The assertions assume that the converter answers each `convStart` with exactly one `convDone` pulse. They also assume that `eocClr`, `swStart` and `extTrig` are single-cycle pulses, and that reset holds until the clock runs. The bench stub returns one `convDone` two cycles after each observed start, never unprompted. After every abort, the bench keeps `cfgEnable` low long enough for any late completion to land while the controller is idle, where it is ignored. Configuration changes are made only with `cfgEnable` low.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_WAIT  = 2'd2
  } seqState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadResult;
    logic stepPos;
    logic wrapPos;
    logic setEoc;
  } seqStrobe_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_scan_pkg::*;
#(
  parameter int BURST_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               trig,
  input  logic               cont,
  input  logic               disc,
  input  logic [BURST_W-1:0] burstM1,
  input  logic               convDone,
  input  logic               atLast,
  output logic               convStart,
  output seqStrobe_t         strobe
);

  seqState_t state, nextState;
  logic [BURST_W-1:0] burstCnt;
  logic burstEnd;

  assign burstEnd  = disc && (burstCnt == burstM1);
  assign convStart = (state == S_START);

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      S_IDLE:  if (trig) nextState = S_START;
      S_START: nextState = S_WAIT;
      S_WAIT: begin
        if (convDone) begin
          strobe.loadResult = 1'b1;
          if (atLast) begin
            strobe.wrapPos = 1'b1;
            strobe.setEoc  = 1'b1;
            nextState = (cont && !disc) ? S_START : S_IDLE;
          end else begin
            strobe.stepPos = 1'b1;
            nextState = burstEnd ? S_IDLE : S_START;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      burstCnt <= '0;
    end else if (!enable) begin
      state    <= S_IDLE;
      burstCnt <= '0;
    end else begin
      state <= nextState;
      if (strobe.loadResult) begin
        if (atLast || burstEnd || !disc) burstCnt <= '0;
        else burstCnt <= burstCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_scan_pkg::*;
#(
  parameter int CHAN_W = 5,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 12,
  localparam int POS_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    scan,
  input  logic [POS_W-1:0]        lenM1,
  input  logic [DEPTH*CHAN_W-1:0] chanList,
  input  logic [DATA_W-1:0]       convData,
  input  logic                    eocClr,
  input  seqStrobe_t              strobe,
  output logic [CHAN_W-1:0]       convChan,
  output logic                    atLast,
  output logic [DATA_W-1:0]       resultData,
  output logic                    dmaReq,
  output logic                    eocFlag
);

  logic [CHAN_W-1:0] chanArr [DEPTH];
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  lastIdx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_unpack
    assign chanArr[i] = chanList[i*CHAN_W +: CHAN_W];
  end

  assign lastIdx  = scan ? lenM1 : '0;
  assign atLast   = (pos == lastIdx);
  assign convChan = chanArr[pos];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos <= '0;
    end else if (!enable || strobe.wrapPos) begin
      pos <= '0;
    end else if (strobe.stepPos) begin
      pos <= pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultData <= '0;
      dmaReq     <= 1'b0;
      eocFlag    <= 1'b0;
    end else begin
      dmaReq <= strobe.loadResult;
      if (strobe.loadResult) resultData <= convData;
      if (strobe.setEoc) eocFlag <= 1'b1;
      else if (eocClr)   eocFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_seq_scan.sv
module adc_seq_scan
  import adc_scan_pkg::*;
#(
  parameter int CHAN_W  = 5,
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 12,
  parameter int BURST_W = 3,
  localparam int POS_W  = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgEnable,
  input  logic                    cfgScan,
  input  logic                    cfgCont,
  input  logic                    cfgDisc,
  input  logic [BURST_W-1:0]      cfgBurstM1,
  input  logic [POS_W-1:0]        cfgLenM1,
  input  logic [DEPTH*CHAN_W-1:0] cfgChanList,
  input  logic                    cfgEocIe,
  input  logic                    swStart,
  input  logic                    extTrig,
  input  logic                    eocClr,
  output logic                    convStart,
  output logic [CHAN_W-1:0]       convChan,
  input  logic                    convDone,
  input  logic [DATA_W-1:0]       convData,
  output logic [DATA_W-1:0]       resultData,
  output logic                    dmaReq,
  output logic                    eocFlag,
  output logic                    eocIrq
);

  seqStrobe_t strobe;
  logic atLast;

  adc_seq_ctrl #(.BURST_W(BURST_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (cfgEnable),
    .trig     (swStart | extTrig),
    .cont     (cfgCont),
    .disc     (cfgDisc),
    .burstM1  (cfgBurstM1),
    .convDone (convDone),
    .atLast   (atLast),
    .convStart(convStart),
    .strobe   (strobe)
  );

  adc_seq_dpath #(.CHAN_W(CHAN_W), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (cfgEnable),
    .scan      (cfgScan),
    .lenM1     (cfgLenM1),
    .chanList  (cfgChanList),
    .convData  (convData),
    .eocClr    (eocClr),
    .strobe    (strobe),
    .convChan  (convChan),
    .atLast    (atLast),
    .resultData(resultData),
    .dmaReq    (dmaReq),
    .eocFlag   (eocFlag)
  );

  assign eocIrq = eocFlag & cfgEocIe;

endmodule

// File: rtl/adc_seq_scan_chk.sv
module adc_seq_scan_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgEnable,
  input logic              convStart,
  input logic              convDone,
  input logic [DATA_W-1:0] resultData,
  input logic              dmaReq,
  input logic              eocFlag,
  input logic              eocClr
);

  a_r2_start_enabled: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> $past(cfgEnable));

  a_r3_dma_after_done: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> $past(convDone));

  a_r3_result_holds: assert property (@(posedge clk) disable iff (!rstN)
    !dmaReq |-> $stable(resultData));

  a_r4_eoc_with_result: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eocFlag) |-> dmaReq);

  a_r8_eoc_clear_only: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eocFlag) |-> $past(eocClr));

  a_r11_single_start: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

endmodule

bind adc_seq_scan adc_seq_scan_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgEnable (cfgEnable),
  .convStart (convStart),
  .convDone  (convDone),
  .resultData(resultData),
  .dmaReq    (dmaReq),
  .eocFlag   (eocFlag),
  .eocClr    (eocClr)
);

// File: tb/adc_seq_scan_tb.sv
`timescale 1ns/1ps
module adc_seq_scan_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0, cfgScan = 1'b0, cfgCont = 1'b0, cfgDisc = 1'b0;
  logic [2:0]  cfgBurstM1 = '0;
  logic [3:0]  cfgLenM1 = '0;
  logic [79:0] cfgChanList = '0;
  logic        cfgEocIe = 1'b0, swStart = 1'b0, extTrig = 1'b0, eocClr = 1'b0;
  logic        convStart, convDone = 1'b0;
  logic [4:0]  convChan;
  logic [11:0] convData = '0, resultData;
  logic        dmaReq, eocFlag, eocIrq;

  int checks = 0, fails = 0, resCount = 0, cycles = 0;
  int expPos = 0, stubCnt = 0;
  logic [4:0] stubChan = '0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_seq_scan u_dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgScan(cfgScan),
    .cfgCont(cfgCont), .cfgDisc(cfgDisc), .cfgBurstM1(cfgBurstM1),
    .cfgLenM1(cfgLenM1), .cfgChanList(cfgChanList), .cfgEocIe(cfgEocIe),
    .swStart(swStart), .extTrig(extTrig), .eocClr(eocClr),
    .convStart(convStart), .convChan(convChan), .convDone(convDone),
    .convData(convData), .resultData(resultData), .dmaReq(dmaReq),
    .eocFlag(eocFlag), .eocIrq(eocIrq)
  );

  function automatic logic [4:0] chanOf(int i);
    return 5'((i * 7 + 3) % 32);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Converter stub: done two cycles after each start; monitor: order check
  always @(negedge clk) begin
    if (stubCnt > 0) begin
      stubCnt--;
      if (stubCnt == 0) begin
        convDone = 1'b1;
        convData = 12'h800 | 12'(stubChan);
      end
    end else begin
      convDone = 1'b0;
    end
    if (convStart) begin
      stubCnt  = 2;
      stubChan = convChan;
    end
    if (!cfgEnable) expPos = 0;
    if (dmaReq) begin
      resCount++;
      // R1 and R12: entry order from 0
      check(resultData == (12'h800 | 12'(chanOf(expPos))), "R1 channel order",
            int'(resultData), int'(12'h800 | 12'(chanOf(expPos))));
      expPos = (expPos == (cfgScan ? int'(cfgLenM1) : 0)) ? 0 : expPos + 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(bit scan, bit cont, bit disc, int burst, int len);
    @(negedge clk);
    cfgEnable = 1'b0;
    waitCyc(6);
    cfgScan = scan; cfgCont = cont; cfgDisc = disc;
    cfgBurstM1 = 3'(burst); cfgLenM1 = 4'(len);
    eocClr = 1'b1;
    @(negedge clk);
    eocClr = 1'b0;
    cfgEnable = 1'b1;
    @(negedge clk);
  endtask

  task automatic trigSw();
    swStart = 1'b1;
    @(negedge clk);
    swStart = 1'b0;
  endtask

  task automatic trigExt();
    extTrig = 1'b1;
    @(negedge clk);
    extTrig = 1'b0;
  endtask

  typedef struct packed {
    logic       scan;
    logic       cont;
    logic       disc;
    logic [2:0] burst;
    logic [3:0] len;
    logic [4:0] expCnt;
    logic       expEoc;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 1'b0, 1'b0, 3'd0, 4'd7,  5'd8,  1'b1},
    '{1'b1, 1'b0, 1'b0, 3'd0, 4'd4,  5'd5,  1'b1},
    '{1'b0, 1'b0, 1'b0, 3'd0, 4'd5,  5'd1,  1'b1},
    '{1'b1, 1'b0, 1'b1, 3'd2, 4'd7,  5'd3,  1'b0},
    '{1'b1, 1'b0, 1'b0, 3'd0, 4'd0,  5'd1,  1'b1},
    '{1'b1, 1'b0, 1'b0, 3'd0, 4'd15, 5'd16, 1'b1}
  };

  initial begin
    int base;
    for (int i = 0; i < 16; i++) cfgChanList[i*5 +: 5] = chanOf(i);
    waitCyc(3);
    // Reset state
    check(convStart == 1'b0 && dmaReq == 1'b0, "R3 reset strobes", int'(dmaReq), 0);
    check(eocFlag == 1'b0 && resultData == '0, "R4 reset flag", int'(eocFlag), 0);
    rstN = 1'b1;
    waitCyc(2);

    // Vector table: length encoding, entry-0 mode, first burst
    for (int v = 0; v < 6; v++) begin
      string tag;
      tag = VEC[v].disc ? "R9 burst count" : (!VEC[v].scan ? "R13 single entry" : "R7 length");
      setup(VEC[v].scan, VEC[v].cont, VEC[v].disc, int'(VEC[v].burst), int'(VEC[v].len));
      base = resCount;
      trigSw();
      waitCyc(120);
      check(resCount - base == int'(VEC[v].expCnt), tag, resCount - base, int'(VEC[v].expCnt));
      check(eocFlag == VEC[v].expEoc, "R4 flag after run", int'(eocFlag), int'(VEC[v].expEoc));
    end

    // R2: trigger with enable low does nothing
    setup(1, 0, 0, 0, 0);
    cfgEnable = 1'b0;
    waitCyc(6);
    base = resCount;
    trigSw();
    trigExt();
    waitCyc(30);
    check(resCount == base, "R2 disabled trigger", resCount - base, 0);
    cfgEnable = 1'b1;
    @(negedge clk);
    trigExt();
    waitCyc(30);
    check(resCount - base == 1, "R2 external trigger", resCount - base, 1);

    // R4 mid-sequence flag stays low; R8 clear; R5 interrupt
    setup(1, 0, 0, 0, 7);
    trigSw();
    waitCyc(14);
    check(eocFlag == 1'b0, "R4 no flag mid-sequence", int'(eocFlag), 0);
    waitCyc(100);
    check(eocFlag == 1'b1, "R4 flag at end", int'(eocFlag), 1);
    cfgEocIe = 1'b1;
    @(negedge clk);
    check(eocIrq == 1'b1, "R5 irq enabled", int'(eocIrq), 1);
    cfgEocIe = 1'b0;
    @(negedge clk);
    check(eocIrq == 1'b0, "R5 irq masked", int'(eocIrq), 0);
    eocClr = 1'b1;
    @(negedge clk);
    eocClr = 1'b0;
    check(eocFlag == 1'b0, "R8 flag cleared", int'(eocFlag), 1'b0);
    cfgEocIe = 1'b1;
    @(negedge clk);
    check(eocIrq == 1'b0, "R5 irq needs flag", int'(eocIrq), 0);
    cfgEocIe = 1'b0;

    // R11: trigger while busy ignored
    setup(1, 0, 0, 0, 7);
    base = resCount;
    trigSw();
    waitCyc(10);
    trigExt();
    waitCyc(140);
    check(resCount - base == 8, "R11 busy trigger ignored", resCount - base, 8);

    // R6: continuous restart
    setup(1, 1, 0, 0, 2);
    base = resCount;
    trigSw();
    waitCyc(100);
    check(resCount - base >= 12, "R6 continuous restart", resCount - base, 12);
    check(eocFlag == 1'b1, "R6 flag in continuous", int'(eocFlag), 1);

    // R9/R10: bursts resume, short last burst, wrap to entry 0
    setup(1, 0, 1, 2, 7);
    base = resCount;
    trigSw();
    waitCyc(40);
    check(resCount - base == 3, "R9 burst one", resCount - base, 3);
    check(eocFlag == 1'b0, "R9 no flag after burst", int'(eocFlag), 0);
    base = resCount;
    trigExt();
    waitCyc(40);
    check(resCount - base == 3, "R9 burst two", resCount - base, 3);
    base = resCount;
    trigSw();
    waitCyc(40);
    check(resCount - base == 2, "R10 short last burst", resCount - base, 2);
    check(eocFlag == 1'b1, "R10 flag at end", int'(eocFlag), 1);
    base = resCount;
    trigSw();
    waitCyc(40);
    check(resCount - base == 3, "R10 wrap burst", resCount - base, 3);

    // R12: abort mid-sequence rewinds
    setup(1, 0, 0, 0, 7);
    trigSw();
    waitCyc(10);
    cfgEnable = 1'b0;
    waitCyc(8);
    check(convStart == 1'b0, "R12 idle after abort", int'(convStart), 0);
    cfgEnable = 1'b1;
    @(negedge clk);
    base = resCount;
    trigSw();
    waitCyc(140);
    check(resCount - base == 8, "R12 full run after abort", resCount - base, 8);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule